// File: doc/BRIEF.md
# Periodic/Nonperiodic DMA Time-Share Scheduler

This block divides each USB (micro)frame between two classes of DMA work: fetching data for periodic IN endpoints and servicing nonperiodic endpoints. A start-of-frame pulse opens a new frame and clears a cycle counter. While any periodic endpoint is active, the periodic class is granted from the first cycle of the frame until a programmed share of the frame length has gone by. The nonperiodic class holds the grant for the rest of that frame. When no periodic endpoint is active, the nonperiodic class holds the grant for the whole frame.

The share comes from a 2-bit interval code held in a 32-bit configuration register. The code selects one quarter, one half or three quarters of the frame. The frame length, in clock cycles, is a port value. The scheduler latches the code at each start of frame, so the split stays fixed for the whole frame. The two grant outputs only tell the DMA engine which class to serve next. The data movement, bus transfers and endpoint FIFOs lie outside this block.

Three named states drive the grant: `ST_IDLE` (after reset, before the first start of frame), `ST_PERIODIC` and `ST_NONPERIODIC`. The transitions are:
- `ST_IDLE` goes to the periodic or nonperiodic state on the first start of frame.
- `ST_PERIODIC` goes to `ST_NONPERIODIC` when the count reaches the threshold or when the active flag drops.
- `ST_NONPERIODIC` goes to `ST_PERIODIC` on a start of frame with periodic work active, or when the active flag rises while the count is still below the threshold.

Top module: `dma_share_sched`

## Requirements
- R1: After reset, the configuration register reads 0x0220_0000, so the interval code in bits 25:24 is 10 (three quarters). Until the first start-of-frame pulse the nonperiodic grant is asserted and the periodic grant is not, whatever the active flag is.
- R2: In every cycle exactly one of `grant_per_o` and `grant_np_o` is high.
- R3: Let L be the frame length. The interval code 00 gives a threshold of floor(L/4), 01 gives floor(L/2), and 10 gives floor(L/2)+floor(L/4). The count is 0 in the cycle after the clock edge that samples the start-of-frame pulse and rises by 1 each cycle. With the active flag high, the periodic grant is asserted in each cycle whose count is below the threshold.
- R4: Once the count reaches the threshold, the nonperiodic grant holds for the rest of the frame.
- R5: If the active flag is low when the frame starts and stays low, the nonperiodic grant holds for the whole frame, whatever the interval code.
- R6: The reserved interval code 11 behaves exactly like code 10.
- R7: Configuration bits 31:26 always read 0 and bits 23:13 always read 0x100, so bit 21 is the only one set among them. Writes to these bits have no effect. Bits 25:24 and 12:0 read back the value last written.
- R8: The interval code is taken from the register at each start of frame. A write in the middle of a frame changes the split only from the next frame.
- R9: If the active flag is low at a clock edge, the periodic grant is low in the following cycle.
- R10: If the active flag rises in the middle of a frame, the periodic grant is asserted from the next cycle, but only if the count in that cycle is below the threshold.
- R11: Without a further start-of-frame pulse, the count stops at L and the nonperiodic grant holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame pulse, one cycle |
| frame_len_i | input | CNT_W | Frame length in clock cycles |
| per_active_i | input | 1 | High while any periodic endpoint is active |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration register contents |
| grant_per_o | output | 1 | Periodic class granted |
| grant_np_o | output | 1 | Nonperiodic class granted |

## Verification
The bench goes after the exact cycle where the periodic grant ends, using frame lengths that are not multiples of four. A design that rounds the threshold differently, or that starts counting one cycle late, would shift that edge by a cycle. It drops and raises the active flag in the middle of a frame, before and after the threshold. A design that ignored the flag, or that granted periodic work after the share had run out, would show the wrong class. It also writes the interval code in the middle of a frame, programs the reserved code and runs long stretches with no start of frame. A design that applied the code at once, left code 11 undefined or let the counter wrap back into a periodic window would then fail.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_PERIODIC    = 2'd1,
        ST_NONPERIODIC = 2'd2
    } sched_state_e;

    typedef enum logic [1:0] {
        IVL_QUARTER = 2'b00,
        IVL_HALF    = 2'b01,
        IVL_3QUART  = 2'b10,
        IVL_RSVD    = 2'b11
    } ivl_code_e;

    localparam int          CFG_W       = 32;
    localparam int          IVL_LSB     = 24;
    localparam int          IVL_W       = 2;
    localparam logic [31:0] CFG_RESET   = 32'h0220_0000;
    localparam logic [31:0] CFG_WR_MASK = 32'h0300_1FFF;

endpackage

// File: rtl/dss_cfg_reg.sv
module dss_cfg_reg
    import dss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output logic [IVL_W-1:0] ivl_code_o
);

    logic [CFG_W-1:0] cfg_q;

    // Only bits covered by the write mask take new data; all others keep reset value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_i) begin
            cfg_q <= (cfg_q & ~CFG_WR_MASK) | (wdata_i & CFG_WR_MASK);
        end
    end

    assign rdata_o    = cfg_q;
    assign ivl_code_o = cfg_q[IVL_LSB +: IVL_W];

endmodule

// File: rtl/dss_frame_timer.sv
module dss_frame_timer
    import dss_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] frame_len_i,
    input  logic [IVL_W-1:0] ivl_code_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_nxt_o,
    output logic [CNT_W-1:0] thr_cur_o,
    output logic [CNT_W-1:0] thr_nxt_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [IVL_W-1:0] code_q;
    logic [IVL_W-1:0] code_eff;

    function automatic logic [CNT_W-1:0] share_of(input logic [CNT_W-1:0] len,
                                                  input logic [IVL_W-1:0] code);
        logic [CNT_W-1:0] quarter;
        logic [CNT_W-1:0] half;
        quarter = len >> 2;
        half    = len >> 1;
        unique case (code)
            IVL_QUARTER: share_of = quarter;
            IVL_HALF:    share_of = half;
            default:     share_of = half + quarter;  // 3/4, reserved code folded here
        endcase
    endfunction

    always_comb begin
        if (sof_i) begin
            cnt_nxt = '0;
        end else if (cnt_q < frame_len_i) begin
            cnt_nxt = cnt_q + 1'b1;
        end else begin
            cnt_nxt = cnt_q;
        end
    end

    assign code_eff = sof_i ? ivl_code_i : code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= IVL_3QUART;
        end else begin
            cnt_q <= cnt_nxt;
            if (sof_i) begin
                code_q <= ivl_code_i;
            end
        end
    end

    assign cnt_q_o   = cnt_q;
    assign cnt_nxt_o = cnt_nxt;
    assign thr_cur_o = share_of(frame_len_i, code_q);
    assign thr_nxt_o = share_of(frame_len_i, code_eff);

endmodule

// File: rtl/dss_grant_fsm.sv
module dss_grant_fsm
    import dss_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic             per_active_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [CNT_W-1:0] thr_nxt_i,
    output sched_state_e     state_o,
    output logic             grant_per_o,
    output logic             grant_np_o
);

    sched_state_e state_q;
    sched_state_e state_d;
    logic         want_per;

    assign want_per = per_active_i && (cnt_nxt_i < thr_nxt_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_i) begin
                    state_d = want_per ? ST_PERIODIC : ST_NONPERIODIC;
                end
            end
            ST_PERIODIC: begin
                if (!want_per) begin
                    state_d = ST_NONPERIODIC;
                end
            end
            ST_NONPERIODIC: begin
                if (want_per) begin
                    state_d = ST_PERIODIC;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant_per_o = 1'b0;
        grant_np_o  = 1'b1;
        unique case (state_q)
            ST_PERIODIC: begin
                grant_per_o = 1'b1;
                grant_np_o  = 1'b0;
            end
            ST_IDLE, ST_NONPERIODIC: begin
                grant_per_o = 1'b0;
                grant_np_o  = 1'b1;
            end
            default: begin
                grant_per_o = 1'b0;
                grant_np_o  = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dma_share_sched.sv
module dma_share_sched
    import dss_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_i,
    input  logic [CNT_W-1:0] frame_len_i,
    input  logic             per_active_i,
    input  logic             cfg_wr_i,
    input  logic [31:0]      cfg_wdata_i,
    output logic [31:0]      cfg_rdata_o,
    output logic             grant_per_o,
    output logic             grant_np_o
);

    logic [IVL_W-1:0] ivl_code;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] thr_cur;
    logic [CNT_W-1:0] thr_nxt;
    sched_state_e     state;

    dss_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cfg_wr_i),
        .wdata_i    (cfg_wdata_i),
        .rdata_o    (cfg_rdata_o),
        .ivl_code_o (ivl_code)
    );

    dss_frame_timer #(.CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_i       (sof_i),
        .frame_len_i (frame_len_i),
        .ivl_code_i  (ivl_code),
        .cnt_q_o     (cnt_q),
        .cnt_nxt_o   (cnt_nxt),
        .thr_cur_o   (thr_cur),
        .thr_nxt_o   (thr_nxt)
    );

    dss_grant_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof_i        (sof_i),
        .per_active_i (per_active_i),
        .cnt_nxt_i    (cnt_nxt),
        .thr_nxt_i    (thr_nxt),
        .state_o      (state),
        .grant_per_o  (grant_per_o),
        .grant_np_o   (grant_np_o)
    );

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof_i,
    input logic             per_active_i,
    input logic [CNT_W-1:0] frame_len_i,
    input logic [31:0]      cfg_rdata_o,
    input logic             grant_per_o,
    input logic             grant_np_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] thr_cur
);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({grant_per_o, grant_np_o}) == 1);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sof_i) && $past(per_active_i) && (cnt_q < thr_cur)) |-> grant_per_o);

    p_after_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_i && (cnt_q >= thr_cur)) |=> !grant_per_o);

    p_resv_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata_o[31:26] == 6'd0) && (cfg_rdata_o[23:13] == 11'h100));

    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !per_active_i |=> !grant_per_o);

    p_saturate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_i && (cnt_q == frame_len_i)) |=> $stable(cnt_q));

endmodule

bind dma_share_sched dss_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof_i        (sof_i),
    .per_active_i (per_active_i),
    .frame_len_i  (frame_len_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .grant_per_o  (grant_per_o),
    .grant_np_o   (grant_np_o),
    .cnt_q        (cnt_q),
    .thr_cur      (thr_cur)
);

// File: tb/dma_share_sched_tb.sv
module dma_share_sched_tb;

    localparam int CNT_W = 16;

    typedef struct packed {
        logic [1:0]  code;
        logic [15:0] len;
        logic        act;
        logic [15:0] thr;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{2'b00, 16'd40,  1'b1, 16'd10},
        '{2'b01, 16'd40,  1'b1, 16'd20},
        '{2'b10, 16'd40,  1'b1, 16'd30},
        '{2'b11, 16'd40,  1'b1, 16'd30},
        '{2'b00, 16'd37,  1'b1, 16'd9},
        '{2'b01, 16'd37,  1'b1, 16'd18},
        '{2'b10, 16'd37,  1'b1, 16'd27},
        '{2'b10, 16'd40,  1'b0, 16'd0},
        '{2'b01, 16'd3,   1'b1, 16'd1},
        '{2'b00, 16'd3,   1'b1, 16'd0},
        '{2'b11, 16'd101, 1'b0, 16'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sof_i;
    logic [CNT_W-1:0] frame_len_i;
    logic             per_active_i;
    logic             cfg_wr_i;
    logic [31:0]      cfg_wdata_i;
    logic [31:0]      cfg_rdata_o;
    logic             grant_per_o;
    logic             grant_np_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    dma_share_sched #(.CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof_i        (sof_i),
        .frame_len_i  (frame_len_i),
        .per_active_i (per_active_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_wdata_i  (cfg_wdata_i),
        .cfg_rdata_o  (cfg_rdata_o),
        .grant_per_o  (grant_per_o),
        .grant_np_o   (grant_np_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] val);
        @(negedge clk);
        cfg_wr_i    = 1'b1;
        cfg_wdata_i = val;
        @(negedge clk);
        cfg_wr_i    = 1'b0;
    endtask

    // Starts a frame and compares both grants in every cycle; one check per frame.
    // Sample j is the cycle whose count is j. Event changes apply from sample j+1.
    task automatic run_frame(input logic act0, input int len, input int thr,
                             input int extra, input int ev_at, input logic ev_act,
                             input int wr_at, input logic [31:0] wr_val,
                             input string req);
        logic act;
        logic exp;
        int   bad;
        int   bad_j;
        logic bad_per;
        logic bad_np;
        bad     = 0;
        bad_j   = 0;
        bad_per = 1'b0;
        bad_np  = 1'b0;
        @(negedge clk);
        sof_i        = 1'b1;
        frame_len_i  = CNT_W'(len);
        per_active_i = act0;
        act          = act0;
        @(negedge clk);
        sof_i = 1'b0;
        for (int j = 0; j <= len + extra; j++) begin
            if (j > 0) @(negedge clk);
            cfg_wr_i = 1'b0;
            exp = act && (j < thr);
            if ((grant_per_o !== exp) || (grant_np_o !== !exp)) begin
                if (bad == 0) begin
                    bad_j   = j;
                    bad_per = grant_per_o;
                    bad_np  = grant_np_o;
                end
                bad++;
            end
            if (j == ev_at) begin
                per_active_i = ev_act;
                act          = ev_act;
            end
            if (j == wr_at) begin
                cfg_wr_i    = 1'b1;
                cfg_wdata_i = wr_val;
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: cycle %0d per/np actual %0b%0b expected %0b%0b (%0d bad cycles)",
                     req, bad_j, bad_per, bad_np,
                     (act0 && bad_j < thr), !(act0 && bad_j < thr), bad);
        end
    endtask

    initial begin
        rst_n        = 1'b0;
        sof_i        = 1'b0;
        frame_len_i  = CNT_W'(40);
        per_active_i = 1'b0;
        cfg_wr_i     = 1'b0;
        cfg_wdata_i  = '0;
        repeat (3) @(negedge clk);
        rst_n        = 1'b1;
        per_active_i = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset value and idle grant before any frame starts
        check(cfg_rdata_o == 32'h0220_0000, "R1 cfg reset", cfg_rdata_o, 32'h0220_0000);
        check(grant_np_o && !grant_per_o, "R1 idle grant",
              {30'd0, grant_per_o, grant_np_o}, 32'd1);

        // R2 R3 R4 R5 R6 R11: vector table walk
        for (int v = 0; v < NVEC; v++) begin
            cfg_write({6'd0, VEC[v].code, 24'd0});
            run_frame(VEC[v].act, int'(VEC[v].len), int'(VEC[v].thr), 4,
                      -1, 1'b0, -1, 32'd0, "R3/R4/R5/R6 vector");
        end

        // R7: reserved bits hold, writable fields follow the data
        cfg_write(32'hFFFF_FFFF);
        check(cfg_rdata_o == 32'h0320_1FFF, "R7 write ones", cfg_rdata_o, 32'h0320_1FFF);
        cfg_write(32'h0000_0000);
        check(cfg_rdata_o == 32'h0020_0000, "R7 write zeros", cfg_rdata_o, 32'h0020_0000);

        // R8: mid-frame code change waits for the next frame
        cfg_write(32'h0000_0000);
        run_frame(1'b1, 40, 10, 2, -1, 1'b0, 3, 32'h0200_0000, "R8 current frame");
        run_frame(1'b1, 40, 30, 2, -1, 1'b0, -1, 32'd0, "R8 next frame");

        // R9: flag drops inside the periodic window
        run_frame(1'b1, 40, 30, 2, 5, 1'b0, -1, 32'd0, "R9 drop");

        // R10: flag rises below and above the threshold
        run_frame(1'b0, 40, 30, 2, 4, 1'b1, -1, 32'd0, "R10 rise early");
        run_frame(1'b0, 40, 30, 2, 32, 1'b1, -1, 32'd0, "R10 rise late");

        // R11: long stretch with no start of frame keeps nonperiodic
        run_frame(1'b1, 20, 15, 300, -1, 1'b0, -1, 32'd0, "R11 saturate");

        // R2: both grants complementary after all of the above
        check(grant_per_o ^ grant_np_o, "R2 one-hot",
              {30'd0, grant_per_o, grant_np_o}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule